// File: doc/BRIEF.md
# Frame CRC Scrubber with Error Reporting

The scrubber walks a frame-organised memory one word at a time, folds every word into a CRC-16 and compares the result with a stored reference for that frame. The reference values are sampled from an input bus while reset is held. Scanning starts on its own once `init_done` is seen, visits the frames in a fixed cycle and never stops until the next reset. All of the block's work advances on a check tick: a clock enable derived from the base clock by a power-of-two divisor chosen on `div_sel`.

When a frame's CRC does not match, the block runs a serial search for the single bit that explains the syndrome. It writes the frame, word and bit of that bit into a message register, and only then raises `err_flag` for one check period. Between two reports the flag stays low for a guaranteed minimum number of check periods. Logic that consumes the reports captures the message into a readout shift register on each rising edge of the flag and clocks it out serially.

For testing the error path, a 21-bit shadow register is loaded serially and copied into an active fault register on an update strobe. The active fault word names one bit, and that bit is inverted on the data path the next time it is read. After that single use the fault word disarms itself.

Top module: `frame_scrubber`

## Requirements
- R1: After reset `err_flag` and `rd_sdo` are 0 and `mem_addr` is 0. While `init_done` is low the address does not move.
- R2: A check tick occurs every 2^(div_sel+1) base clock cycles, for `div_sel` 0 to 7. During scanning the address advances by exactly one word per tick.
- R3: The CRC of a frame uses polynomial 0x1021 and start value 0xFFFF. It is computed over its 32 words in word order, each word bit 31 first, and compared with reference slot f, which is `golden_crc[16f+15:16f]` sampled while `rst_n` is low. Memory that matches its references never raises `err_flag`.
- R4: For a frame with a single flipped bit, the message reads {frame[13:10], word[9:5], bit[4:0]} and names that bit.
- R5: If no single-bit flip explains the mismatch, the message carries the frame with word and bit fields set to all ones.
- R6: `err_flag` rises only on a check tick, after the message has been written. It stays high for exactly one check period, and the message does not change while it is high.
- R7: After a report `err_flag` stays low for at least 32 check periods. Errors in two consecutive frames give two reports in frame order, each with its own location.
- R8: A `rd_capture` pulse loads the message into the readout register. Each cycle with `rd_shift` high moves it one place toward `rd_sdo`, least significant bit first, and a new capture reloads the same message.
- R9: Injection bits enter the shadow register on `inj_sdi` while `inj_shift` is high, least significant bit first over 21 shifts. Shifting has no effect on scanning until `inj_update` is pulsed.
- R10: The active fault word is {armed[20], frame[19:16], word[15:11], bit[10:6], spare[5:0]}. When armed, the named bit is inverted as it is read, giving a report at that location, and the word is disarmed after that single use.
- R11: `mem_addr` is {frame[8:5], word[4:0]}. Frames are visited 0 to 15 and then from 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low reset; reference CRCs are sampled while low |
| init_done | input | 1 | Scanning may begin once high |
| div_sel | input | 3 | Divisor exponent minus one (divisor 2 to 256) |
| golden_crc | input | 256 | Reference CRCs, 16 bits per frame, frame 0 lowest |
| mem_addr | output | 9 | Word address being read, {frame, word} |
| mem_rdata | input | 32 | Word at `mem_addr`, combinational read |
| inj_sdi | input | 1 | Serial data into the injection shadow register |
| inj_shift | input | 1 | Shift enable for the shadow register |
| inj_update | input | 1 | Copies the shadow into the active fault register |
| rd_capture | input | 1 | Loads the error message into the readout register |
| rd_shift | input | 1 | Shifts the readout register toward `rd_sdo` |
| rd_sdo | output | 1 | Serial readout, least significant bit first |
| err_flag | output | 1 | One-period pulse per error report |

## Verification
The location search is tried with single flipped bits at the two ends of its search order: the last bit of a frame, found on the first step, and the first bit of a frame, found on the last step. It is also tried at interior positions in several frames, which separates a correct word/bit mapping from an off-by-one or reversed mapping. A pair of flipped bits in one word shows whether the unmatched case yields the all-ones code, with the expected location found by brute-force recomputation of the frame CRC for every candidate flip. Errors in two adjacent frames and an armed injection (first without the update strobe, then with it, then again after its single use) tell apart correct report ordering, the flag's low gap, staging through the shadow register and one-shot disarming. A sweep of every divisor setting measures the tick spacing.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    parameter int FRAMES    = 16;
    parameter int WORDS     = 32;
    parameter int DATA_W    = 32;
    parameter int CRC_W     = 16;
    parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021;
    parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;
    parameter int HOLD_LOW  = 32;
    parameter int DIV_SEL_W = 3;
    parameter int DIV_CNT_W = 8;
    parameter int INJ_W     = 21;

    localparam int FRAME_W  = $clog2(FRAMES);
    localparam int WORD_W   = $clog2(WORDS);
    localparam int BIT_W    = $clog2(DATA_W);
    localparam int ADDR_W   = FRAME_W + WORD_W;
    localparam int POS_W    = WORD_W + BIT_W;
    localparam int MSG_W    = FRAME_W + POS_W;
    localparam int HOLD_W   = $clog2(HOLD_LOW + 1);
    localparam int INJ_V    = INJ_W - 1;
    localparam int INJ_F_LO = INJ_V - FRAME_W;
    localparam int INJ_W_LO = INJ_F_LO - WORD_W;
    localparam int INJ_B_LO = INJ_W_LO - BIT_W;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SCAN, ST_CHECK, ST_SEARCH, ST_REPORT, ST_FLAG
    } scan_st_e;

    typedef struct packed {
        scan_st_e             st;
        logic [FRAME_W-1:0]   frame;
        logic [WORD_W-1:0]    word;
        logic [CRC_W-1:0]     crc;
        logic [CRC_W-1:0]     syn;
        logic [CRC_W-1:0]     srch;
        logic [POS_W-1:0]     pos;
        logic [MSG_W-1:0]     msg;
        logic                 flag;
        logic [HOLD_W-1:0]    low;
    } scan_t;

    // Fold one data word into the CRC, most significant bit first.
    function automatic logic [CRC_W-1:0] crc_word(input logic [CRC_W-1:0] c_in,
                                                  input logic [DATA_W-1:0] dat);
        logic [CRC_W-1:0] c;
        logic fb;
        c = c_in;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ dat[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

    // Multiply a syndrome by x modulo the generator.
    function automatic logic [CRC_W-1:0] mulx(input logic [CRC_W-1:0] s);
        return s[CRC_W-1] ? ({s[CRC_W-2:0], 1'b0} ^ CRC_POLY) : {s[CRC_W-2:0], 1'b0};
    endfunction

endpackage

// File: rtl/scrub_clkdiv.sv
module scrub_clkdiv import scrub_pkg::*; (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 tick
);
    typedef struct packed {
        logic [DIV_CNT_W-1:0] cnt;
    } div_t;

    div_t q, d;
    logic [DIV_CNT_W:0]   full_mask;
    logic [DIV_CNT_W-1:0] mask;

    always_comb begin
        full_mask = ((DIV_CNT_W+1)'(1) << ({1'b0, div_sel} + 4'd1)) - (DIV_CNT_W+1)'(1);
        mask      = full_mask[DIV_CNT_W-1:0];
        tick      = ((q.cnt & mask) == mask);
        d         = q;
        d.cnt     = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/scrub_inject.sv
module scrub_inject import scrub_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sdi,
    input  logic               shift_en,
    input  logic               update,
    input  logic               consume,
    output logic               armed,
    output logic [FRAME_W-1:0] tgt_frame,
    output logic [WORD_W-1:0]  tgt_word,
    output logic [BIT_W-1:0]   tgt_bit
);
    localparam int ACT_W = INJ_W - INJ_B_LO;

    typedef struct packed {
        logic [INJ_W-1:0] shadow;
        logic [ACT_W-1:0] fault;
    } inj_t;

    inj_t q, d;

    always_comb begin
        d = q;
        if (shift_en) d.shadow = {sdi, q.shadow[INJ_W-1:1]};
        if (update)       d.fault = q.shadow[INJ_W-1:INJ_B_LO];
        else if (consume) d.fault[ACT_W-1] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign armed     = q.fault[ACT_W-1];
    assign tgt_frame = q.fault[INJ_V-1-INJ_B_LO -: FRAME_W];
    assign tgt_word  = q.fault[INJ_F_LO-1-INJ_B_LO -: WORD_W];
    assign tgt_bit   = q.fault[INJ_W_LO-1-INJ_B_LO -: BIT_W];
endmodule

// File: rtl/scrub_readout.sv
module scrub_readout import scrub_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             shift_en,
    input  logic [MSG_W-1:0] msg,
    output logic             sdo
);
    typedef struct packed {
        logic [MSG_W-1:0] sreg;
    } rd_t;

    rd_t q, d;

    always_comb begin
        d = q;
        if (capture)       d.sreg = msg;
        else if (shift_en) d.sreg = {1'b0, q.sreg[MSG_W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdo = q.sreg[0];
endmodule

// File: rtl/frame_scrubber.sv
module frame_scrubber import scrub_pkg::*; (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    init_done,
    input  logic [DIV_SEL_W-1:0]    div_sel,
    input  logic [FRAMES*CRC_W-1:0] golden_crc,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic [DATA_W-1:0]       mem_rdata,
    input  logic                    inj_sdi,
    input  logic                    inj_shift,
    input  logic                    inj_update,
    input  logic                    rd_capture,
    input  logic                    rd_shift,
    output logic                    rd_sdo,
    output logic                    err_flag
);
    localparam scan_t SCAN_RST = '{st: ST_IDLE, frame: '0, word: '0, crc: CRC_INIT,
                                   syn: '0, srch: '0, pos: '0, msg: '0, flag: 1'b0,
                                   low: HOLD_W'(HOLD_LOW)};

    scan_t q, d;

    logic                tick;
    logic                inj_valid;
    logic [FRAME_W-1:0]  inj_frame;
    logic [WORD_W-1:0]   inj_word;
    logic [BIT_W-1:0]    inj_bit;
    logic                inj_hit;
    logic [DATA_W-1:0]   data_fix;
    logic [MSG_W-1:0]    msg_q;
    logic [WORD_W-1:0]   loc_word;
    logic [FRAME_W-1:0]  frame_nxt;
    logic [CRC_W-1:0]    ref_q [FRAMES];

    scrub_clkdiv u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .tick    (tick)
    );

    scrub_inject u_inj (
        .clk       (clk),
        .rst_n     (rst_n),
        .sdi       (inj_sdi),
        .shift_en  (inj_shift),
        .update    (inj_update),
        .consume   (inj_hit),
        .armed     (inj_valid),
        .tgt_frame (inj_frame),
        .tgt_word  (inj_word),
        .tgt_bit   (inj_bit)
    );

    scrub_readout u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (rd_capture),
        .shift_en (rd_shift),
        .msg      (msg_q),
        .sdo      (rd_sdo)
    );

    // Reference CRCs are sampled while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int f = 0; f < FRAMES; f++) ref_q[f] <= golden_crc[f*CRC_W +: CRC_W];
        end
    end

    assign inj_hit  = inj_valid && tick && (q.st == ST_SCAN) &&
                      (q.frame == inj_frame) && (q.word == inj_word);
    assign data_fix = mem_rdata ^ (inj_hit ? (DATA_W'(1) << inj_bit) : '0);

    always_comb begin
        loc_word  = WORD_W'(WORDS - 1) - q.pos[POS_W-1:BIT_W];
        frame_nxt = (q.frame == FRAME_W'(FRAMES - 1)) ? '0 : q.frame + 1'b1;
        d = q;
        if (tick && !q.flag && (q.low < HOLD_W'(HOLD_LOW))) d.low = q.low + 1'b1;
        case (q.st)
            ST_IDLE: if (tick && init_done) begin
                d.st   = ST_SCAN;
                d.word = '0;
                d.crc  = CRC_INIT;
            end
            ST_SCAN: if (tick) begin
                d.crc = crc_word(q.crc, data_fix);
                if (q.word == WORD_W'(WORDS - 1)) d.st = ST_CHECK;
                else                              d.word = q.word + 1'b1;
            end
            ST_CHECK: if (tick) begin
                if (q.crc != ref_q[q.frame]) begin
                    d.syn  = q.crc ^ ref_q[q.frame];
                    d.srch = CRC_POLY;
                    d.pos  = '0;
                    d.st   = ST_SEARCH;
                end else begin
                    d.frame = frame_nxt;
                    d.word  = '0;
                    d.crc   = CRC_INIT;
                    d.st    = ST_SCAN;
                end
            end
            ST_SEARCH: if (tick) begin
                if (q.srch == q.syn) begin
                    d.msg = {q.frame, loc_word, q.pos[BIT_W-1:0]};
                    d.st  = ST_REPORT;
                end else if (q.pos == '1) begin
                    d.msg = {q.frame, {POS_W{1'b1}}};
                    d.st  = ST_REPORT;
                end else begin
                    d.pos  = q.pos + 1'b1;
                    d.srch = mulx(q.srch);
                end
            end
            ST_REPORT: if (tick && (q.low >= HOLD_W'(HOLD_LOW))) begin
                d.flag = 1'b1;
                d.st   = ST_FLAG;
            end
            ST_FLAG: if (tick) begin
                d.flag  = 1'b0;
                d.low   = '0;
                d.frame = frame_nxt;
                d.word  = '0;
                d.crc   = CRC_INIT;
                d.st    = ST_SCAN;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SCAN_RST;
        else        q <= d;
    end

    assign mem_addr = {q.frame, q.word};
    assign err_flag = q.flag;
    assign msg_q    = q.msg;
endmodule

// File: rtl/frame_scrubber_chk.sv
module frame_scrubber_chk import scrub_pkg::*; (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              err_flag,
    input logic [MSG_W-1:0]  msg,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              inj_hit,
    input logic              inj_update,
    input logic              inj_valid
);
    logic [HOLD_W-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  gap <= HOLD_W'(HOLD_LOW);
        else if (err_flag)                           gap <= '0;
        else if (tick && gap < HOLD_W'(HOLD_LOW))    gap <= gap + 1'b1;
    end

    a_r2_addr_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(mem_addr));

    a_r6_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(tick));

    a_r6_msg_held: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> $stable(msg));

    a_r6_one_period: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && tick) |=> !err_flag);

    a_r6_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !tick) |=> err_flag);

    a_r7_low_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> (gap >= HOLD_W'(HOLD_LOW)));

    a_r10_single_use: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inj_hit) && !$past(inj_update)) |-> !inj_valid);
endmodule

bind frame_scrubber frame_scrubber_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .err_flag   (err_flag),
    .msg        (msg_q),
    .mem_addr   (mem_addr),
    .inj_hit    (inj_hit),
    .inj_update (inj_update),
    .inj_valid  (inj_valid)
);

// File: tb/frame_scrubber_tb.sv
module frame_scrubber_tb;
    import scrub_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    init_done = 1'b0;
    logic [DIV_SEL_W-1:0]    div_sel = '0;
    logic [FRAMES*CRC_W-1:0] golden_crc = '0;
    logic [ADDR_W-1:0]       mem_addr;
    logic [DATA_W-1:0]       mem_rdata;
    logic                    inj_sdi = 1'b0, inj_shift = 1'b0, inj_update = 1'b0;
    logic                    rd_capture = 1'b0, rd_shift = 1'b0;
    logic                    rd_sdo, err_flag;

    logic [DATA_W-1:0] mem [FRAMES*WORDS];
    int  nchk = 0, nfail = 0;
    bit  done = 0;

    always #10 clk = ~clk;
    assign mem_rdata = mem[mem_addr];

    frame_scrubber u_dut (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] tb_crc(input logic [15:0] c_in, input logic [31:0] w);
        logic [15:0] c = c_in;
        for (int i = 31; i >= 0; i--) begin
            c[15] = c[15] ^ w[i];
            if (c[15]) c = (c << 1) ^ 16'h1021;
            else       c = c << 1;
        end
        return c;
    endfunction

    function automatic logic [15:0] frame_crc(input int f, input int fw, input int fb, input bit flip);
        logic [15:0] c = 16'hFFFF;
        logic [31:0] w;
        for (int k = 0; k < 32; k++) begin
            w = mem[f*32 + k];
            if (flip && k == fw) w[fb] = ~w[fb];
            c = tb_crc(c, w);
        end
        return c;
    endfunction

    task automatic wait_frame(input int f);
        int n = 0;
        while (int'(mem_addr[8:5]) != f && n < 6000) begin @(negedge clk); n++; end
    endtask

    task automatic wait_rise(output bit ok, output longint t);
        int n = 0;
        ok = 0; t = 0;
        while (err_flag && n < 9000) begin @(negedge clk); n++; end
        while (!err_flag && n < 9000) begin @(negedge clk); n++; end
        if (err_flag) begin ok = 1; t = $time; end
    endtask

    task automatic high_len(output int cnt, output longint t_fall);
        cnt = 0;
        while (err_flag) begin @(negedge clk); cnt++; end
        t_fall = $time;
    endtask

    task automatic read_msg(output logic [13:0] m);
        rd_capture = 1'b1;
        @(negedge clk);
        rd_capture = 1'b0;
        rd_shift   = 1'b1;
        for (int i = 0; i < 14; i++) begin
            m[i] = rd_sdo;
            @(negedge clk);
        end
        rd_shift = 1'b0;
    endtask

    task automatic count_rises(input int cycles, output int cnt);
        logic prev = err_flag;
        cnt = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (err_flag && !prev) cnt++;
            prev = err_flag;
        end
    endtask

    task automatic measure_tick(input int dsel);
        logic [8:0] prev;
        longint t_a = -1;
        bit got = 0;
        div_sel = 3'(dsel);
        prev = mem_addr;
        for (int n = 0; n < 3000 && !got; n++) begin
            @(negedge clk);
            if (mem_addr != prev) begin
                if (t_a >= 0 && mem_addr[4:0] >= 2) begin
                    check(($time - t_a) / 20 == (1 << (dsel + 1)), "R2", "tick spacing",
                          ($time - t_a) / 20, 1 << (dsel + 1));
                    check(mem_addr == prev + 1, "R11", "word step", mem_addr, prev + 1);
                    got = 1;
                end
                t_a  = $time;
                prev = mem_addr;
            end
        end
        if (!got) check(0, "R2", "no tick seen", 0, 1 << (dsel + 1));
    endtask

    task automatic single_case(input int f, input int w, input int b);
        bit ok; longint t, tf; int hi; logic [13:0] m;
        wait_frame((f + 15) % 16);
        mem[f*32 + w][b] = ~mem[f*32 + w][b];
        wait_rise(ok, t);
        check(ok, "R4", "flag for single error", ok, 1);
        high_len(hi, tf);
        check(hi == 2, "R6", "flag high clocks", hi, 2);
        mem[f*32 + w][b] = ~mem[f*32 + w][b];
        read_msg(m);
        check(m == {4'(f), 5'(w), 5'(b)}, "R4", "location", m, {4'(f), 5'(w), 5'(b)});
    endtask

    initial begin
        bit ok; longint t1, t2, tf; int hi, cnt; logic [13:0] m, m2, exp_m;
        logic [20:0] iw;
        bit seen_top, wrapped;
        logic [8:0] pa;

        for (int i = 0; i < FRAMES*WORDS; i++)
            mem[i] = (32'(i) * 32'h9E3779B1) ^ (32'(i) << 11) ^ 32'h5A5A0F0F;
        for (int f = 0; f < FRAMES; f++) golden_crc[f*16 +: 16] = frame_crc(f, 0, 0, 0);

        repeat (4) @(negedge clk);
        check(err_flag == 0, "R1", "flag in reset", err_flag, 0);
        check(rd_sdo == 0, "R1", "sdo in reset", rd_sdo, 0);
        check(mem_addr == 0, "R1", "addr in reset", mem_addr, 0);
        rst_n = 1'b1;
        repeat (200) @(negedge clk);
        check(mem_addr == 0, "R1", "addr without init_done", mem_addr, 0);
        check(err_flag == 0, "R1", "flag without init_done", err_flag, 0);

        init_done = 1'b1;
        for (int dsel = 0; dsel < 8; dsel++) measure_tick(dsel);
        div_sel = '0;

        // R11: frame order wraps from the last word of frame 15 to word 0 of frame 0
        seen_top = 0; wrapped = 0; pa = mem_addr;
        for (int n = 0; n < 4000 && !wrapped; n++) begin
            @(negedge clk);
            if (mem_addr != pa) begin
                if (seen_top) begin
                    check(mem_addr == 0, "R11", "wrap address", mem_addr, 0);
                    wrapped = 1;
                end
                if (mem_addr == 9'h1FF) seen_top = 1;
                pa = mem_addr;
            end
        end
        check(wrapped, "R11", "wrap observed", wrapped, 1);

        count_rises(2500, cnt);
        check(cnt == 0, "R3", "clean memory reports", cnt, 0);

        single_case(3, 31, 0);
        single_case(7, 0, 31);
        single_case(12, 17, 9);
        single_case(0, 5, 22);
        single_case(15, 30, 31);

        // R8: a second capture reloads the same message
        read_msg(m2);
        check(m2 == {4'd15, 5'd30, 5'd31}, "R8", "recapture", m2, {4'd15, 5'd30, 5'd31});

        // R7: adjacent frames in error
        wait_frame(8);
        mem[9*32 + 4][4]   = ~mem[9*32 + 4][4];
        mem[10*32 + 20][1] = ~mem[10*32 + 20][1];
        wait_rise(ok, t1);
        check(ok, "R7", "first report", ok, 1);
        high_len(hi, tf);
        read_msg(m);
        check(m == {4'd9, 5'd4, 5'd4}, "R7", "first location", m, {4'd9, 5'd4, 5'd4});
        wait_rise(ok, t2);
        check(ok, "R7", "second report", ok, 1);
        check((t2 - tf) / 20 >= 64, "R7", "low gap clocks", (t2 - tf) / 20, 64);
        mem[9*32 + 4][4]   = ~mem[9*32 + 4][4];
        mem[10*32 + 20][1] = ~mem[10*32 + 20][1];
        high_len(hi, tf);
        read_msg(m);
        check(m == {4'd10, 5'd20, 5'd1}, "R7", "second location", m, {4'd10, 5'd20, 5'd1});

        // R5: two flipped bits in one word, expected by brute force over single flips
        wait_frame(1);
        mem[2*32 + 5][3] = ~mem[2*32 + 5][3];
        mem[2*32 + 5][4] = ~mem[2*32 + 5][4];
        exp_m = {4'd2, 5'h1F, 5'h1F};
        for (int k = 1023; k >= 0; k--)
            if (frame_crc(2, 31 - k / 32, k % 32, 1) == golden_crc[2*16 +: 16])
                exp_m = {4'd2, 5'(31 - k / 32), 5'(k % 32)};
        wait_rise(ok, t1);
        check(ok, "R5", "report for double error", ok, 1);
        high_len(hi, tf);
        mem[2*32 + 5][3] = ~mem[2*32 + 5][3];
        mem[2*32 + 5][4] = ~mem[2*32 + 5][4];
        read_msg(m);
        check(m == exp_m, "R5", "unmatched code", m, exp_m);

        // R9: shifting alone does not arm injection
        iw = {1'b1, 4'd6, 5'd12, 5'd7, 6'd0};
        for (int i = 0; i < 21; i++) begin
            inj_sdi = iw[i]; inj_shift = 1'b1;
            @(negedge clk);
        end
        inj_shift = 1'b0;
        count_rises(2500, cnt);
        check(cnt == 0, "R9", "no report before update", cnt, 0);

        // R10: update arms a single injected flip
        inj_update = 1'b1;
        @(negedge clk);
        inj_update = 1'b0;
        wait_rise(ok, t1);
        check(ok, "R10", "injected report", ok, 1);
        high_len(hi, tf);
        read_msg(m);
        check(m == {4'd6, 5'd12, 5'd7}, "R10", "injected location", m, {4'd6, 5'd12, 5'd7});
        count_rises(2500, cnt);
        check(cnt == 0, "R10", "no report after single use", cnt, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule